// File: doc/BRIEF.md
# MSK Modem Byte Transmitter

The block turns bytes that software places in a one-byte holding buffer into a stepped waveform for an external resistive DAC. Each byte goes out most significant bit first. Every bit lasts a fixed number of sub-steps, and each sub-step is marked by a pulse on the baud tick input. During a bit the 3-bit output walks a small sine table. A 1 bit advances the phase twice as fast as a 0 bit, which gives two tones half a bit rate apart. The phase is carried across bit and byte boundaries, so the waveform has no jumps.

Software drives the block through a register-style write port with two locations: the byte buffer and a control word whose bit 0 is the enable. A ready flag tells software when the buffer can accept the next byte. Software writes the two preamble bytes of a message as ordinary data: AAh first, then Ah in the upper nibble with a 4-bit programmable value below it. When the buffer runs dry the output settles at a mid-level idle code. When the block is disabled, the output drives a code that switches every DAC current off. Clearing the enable during a byte lets that byte finish, then switches the output off without raising the flag.

Top module: `msk_byte_tx`

## Requirements
- R1: After reset, dac_code is 3'b111 (off) and irq is 0. While the enable is 0 and no byte is in flight, dac_code stays 3'b111 whatever baud_tick does.
- R2: A write with wr_sel=1 sets the enable from wr_data[0]. With no byte in flight, enable 1 gives dac_code 3'b100 (idle) and enable 0 gives 3'b111.
- R3: A write with wr_sel=0 while enabled and idle starts a transmission within two clock cycles. irq becomes 1, and dac_code shows the code for phase 0, which is 3'b011.
- R4: Bytes go out MSB first, and each bit lasts SUB_STEPS baud ticks. A 16-position phase starts at 0 when a transmission starts from idle. On each tick the phase advances by 2 for a 0 bit and by 4 for a 1 bit, modulo 16. dac_code equals round(3 + 3*sin(2*pi*phase/16)) and is never 3'b111 while a byte is in flight.
- R5: irq is set each time the buffer moves into the shifter, and it stays set until irq_clr is pulsed. A set and a clear in the same cycle leave irq at 1.
- R6: A buffer write made during a byte is held until that byte's last tick. The held byte then follows with no gap, and the phase carries on from where it was.
- R7: If the buffer is empty at the end of a byte, dac_code returns to 3'b100 and stays there.
- R8: If the enable is cleared during a byte, that byte finishes unchanged, and then dac_code is 3'b111. A pending byte is discarded, and irq is not set.
- R9: Buffer writes made while the enable is 0 are ignored. They neither start a transmission nor set irq.
- R10: Two transfers from buffer to shifter are at least 8*SUB_STEPS baud ticks apart, so irq cannot be set again within one byte after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the byte buffer, 1 selects the control word |
| wr_data | input | DATA_W | Write data; bit 0 is the enable when wr_sel=1 |
| irq_clr | input | 1 | Clears the ready flag |
| baud_tick | input | 1 | One pulse per sub-step |
| irq | output | 1 | Buffer-ready flag |
| dac_code | output | 3 | Code for the resistive DAC |

## Verification
Two things can land in the same clock edge: the ready flag being set by a transfer at a byte boundary, and software clearing that flag. The bench provokes this on every other byte of a long back-to-back stream. It raises irq_clr together with the final baud tick of a byte while the next byte is waiting. Because the set wins, the flag must read 1 afterwards. The stream runs through every byte value, and the expected waveform at each sub-step is computed from the phase rule with a real-valued sine.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

  localparam int          PH_W      = 4;
  localparam logic [2:0]  CODE_OFF  = 3'b111;
  localparam logic [2:0]  CODE_IDLE = 3'b100;

  // Sine of 16 phase positions, centred on 3, swing 3; never reaches 7.
  function automatic logic [2:0] sine_code(input logic [PH_W-1:0] ph);
    logic [2:0] c;
    case (ph)
      4'd0:  c = 3'd3;
      4'd1:  c = 3'd4;
      4'd2:  c = 3'd5;
      4'd3:  c = 3'd6;
      4'd4:  c = 3'd6;
      4'd5:  c = 3'd6;
      4'd6:  c = 3'd5;
      4'd7:  c = 3'd4;
      4'd8:  c = 3'd3;
      4'd9:  c = 3'd2;
      4'd10: c = 3'd1;
      4'd11: c = 3'd0;
      4'd12: c = 3'd0;
      4'd13: c = 3'd0;
      4'd14: c = 3'd1;
      default: c = 3'd2;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/msk_tx_timer.sv
module msk_tx_timer #(
  parameter int SUB_STEPS = 4,
  parameter int DATA_W    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic baud_tick,
  output logic step,
  output logic bit_end,
  output logic byte_end
);
  localparam int SUB_W = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_STEPS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bit_q;

  assign step     = active & baud_tick;
  assign bit_end  = step && (sub_q == SUB_LAST);
  assign byte_end = bit_end && (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (step) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/msk_tx_ctrl.sv
module msk_tx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  input  logic              bit_end,
  input  logic              byte_end,
  output logic              enabled,
  output logic              active,
  output logic              cur_bit,
  output logic              start,
  output logic              load,
  output logic              irq
);
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] shreg;
  logic              reload;
  logic              wr_buf;
  logic              wr_ctl;

  assign wr_buf  = wr_en && !wr_sel;
  assign wr_ctl  = wr_en && wr_sel;
  assign start   = !active && buf_full && enabled;
  assign reload  = byte_end && buf_full && enabled;
  assign load    = start || reload;
  assign cur_bit = shreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled <= 1'b0;
    end else if (wr_ctl) begin
      enabled <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (wr_ctl && !wr_data[0]) begin
      buf_full <= 1'b0;
    end else if (wr_buf && enabled) begin
      buf_full <= 1'b1;
      buf_data <= wr_data;
    end else if (load) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
    end else if (byte_end && !reload) begin
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= buf_data;
    end else if (bit_end) begin
      shreg <= {shreg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (load) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/msk_tx_wave.sv
module msk_tx_wave
  import msk_tx_pkg::*;
#(
  parameter int SUB_STEPS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enabled,
  input  logic       active,
  input  logic       start,
  input  logic       step,
  input  logic       cur_bit,
  output logic [2:0] dac_code
);
  localparam int PH_N    = 1 << PH_W;
  localparam int STEP_LO = (PH_N / (2 * SUB_STEPS) > 0) ? PH_N / (2 * SUB_STEPS) : 1;
  localparam int STEP_HI = 2 * STEP_LO;

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= phase_q + (cur_bit ? PH_W'(STEP_HI) : PH_W'(STEP_LO));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= CODE_OFF;
    end else if (active) begin
      dac_code <= sine_code(phase_q);
    end else begin
      dac_code <= enabled ? CODE_IDLE : CODE_OFF;
    end
  end
endmodule

// File: rtl/msk_byte_tx.sv
module msk_byte_tx #(
  parameter int DATA_W    = 8,
  parameter int SUB_STEPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  input  logic              baud_tick,
  output logic              irq,
  output logic [2:0]        dac_code
);
  logic tx_enabled;
  logic tx_active;
  logic tx_cur_bit;
  logic tx_start;
  logic tx_load;
  logic tx_step;
  logic tx_bit_end;
  logic tx_byte_end;

  msk_tx_timer #(.SUB_STEPS(SUB_STEPS), .DATA_W(DATA_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .active   (tx_active),
    .baud_tick(baud_tick),
    .step     (tx_step),
    .bit_end  (tx_bit_end),
    .byte_end (tx_byte_end)
  );

  msk_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq_clr (irq_clr),
    .bit_end (tx_bit_end),
    .byte_end(tx_byte_end),
    .enabled (tx_enabled),
    .active  (tx_active),
    .cur_bit (tx_cur_bit),
    .start   (tx_start),
    .load    (tx_load),
    .irq     (irq)
  );

  msk_tx_wave #(.SUB_STEPS(SUB_STEPS)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .enabled (tx_enabled),
    .active  (tx_active),
    .start   (tx_start),
    .step    (tx_step),
    .cur_bit (tx_cur_bit),
    .dac_code(dac_code)
  );
endmodule

// File: rtl/msk_byte_tx_chk.sv
module msk_byte_tx_chk #(
  parameter int DATA_W    = 8,
  parameter int SUB_STEPS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       active,
  input logic       enabled,
  input logic       load,
  input logic       step,
  input logic       irq,
  input logic       irq_clr,
  input logic [2:0] dac_code
);
  localparam int GAP = DATA_W * SUB_STEPS;

  int gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP;
    end else if (load) begin
      gap_q <= 0;
    end else if (step && gap_q < GAP) begin
      gap_q <= gap_q + 1;
    end
  end

  // R4
  no_off_in_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (dac_code != 3'b111));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R10
  load_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (gap_q >= GAP - 1));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(enabled) && !$past(active)) |-> (dac_code == 3'b100));

  // R1
  off_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(enabled) && !$past(active)) |-> (dac_code == 3'b111));

  // R8
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !irq) |=> !irq);
endmodule

bind msk_byte_tx msk_byte_tx_chk #(.DATA_W(DATA_W), .SUB_STEPS(SUB_STEPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .active  (tx_active),
  .enabled (tx_enabled),
  .load    (tx_load),
  .step    (tx_step),
  .irq     (irq),
  .irq_clr (irq_clr),
  .dac_code(dac_code)
);

// File: tb/msk_byte_tx_tb.sv
module msk_byte_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int SUB_STEPS  = 4;
  localparam int STREAM_N   = 258;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              irq_clr = 1'b0;
  logic              baud_tick = 1'b0;
  logic              irq;
  logic [2:0]        dac_code;

  int n_chk  = 0;
  int n_fail = 0;
  int ph     = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msk_byte_tx #(.DATA_W(DATA_W), .SUB_STEPS(SUB_STEPS)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_clr(irq_clr), .baud_tick(baud_tick), .irq(irq), .dac_code(dac_code)
  );

  function automatic int exp_code(input int p);
    real x;
    x = 3.0 + 3.0 * $sin(2.0 * 3.14159265358979 * p / 16.0);
    return $rtoi(x + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic wr(input logic sel, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic tick(input logic with_clr);
    @(negedge clk); baud_tick = 1'b1; irq_clr = with_clr;
    @(negedge clk); baud_tick = 1'b0; irq_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Runs one byte, checking every sub-step; disables after dis_at sub-steps when dis_at >= 0.
  task automatic run_byte(input logic [7:0] b, input logic clr_last, input int dis_at);
    int k = 0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      for (int s = 0; s < SUB_STEPS; s++) begin
        check("R4 waveform", dac_code, exp_code(ph));
        check("R10 no early irq", irq, 0);
        if (k == dis_at) wr(1'b1, 8'h00);
        tick(clr_last && (i == 0) && (s == SUB_STEPS - 1));
        ph = (ph + (b[i] ? 4 : 2)) % 16;
        k++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset dac", dac_code, 7);
    check("R1 reset irq", irq, 0);
    tick(1'b0);
    check("R1 off under ticks", dac_code, 7);

    wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check("R2 enable idle", dac_code, 4);
    wr(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    check("R2 disable off", dac_code, 7);
    wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check("R2 re-enable idle", dac_code, 4);

    // Continuous stream: preamble AA, A5, then every byte value.
    ph = 0;
    wr(1'b0, 8'hAA);
    repeat (2) @(negedge clk);
    check("R3 start irq", irq, 1);
    check("R3 start code", dac_code, 3);
    for (int idx = 0; idx < STREAM_N; idx++) begin
      logic [7:0] cur;
      logic [7:0] nxt;
      logic       more;
      cur  = (idx == 0) ? 8'hAA : (idx == 1) ? 8'hA5 : 8'(idx - 2);
      nxt  = (idx == 0) ? 8'hA5 : 8'(idx - 1);
      more = (idx < STREAM_N - 1);
      clr_irq();
      check("R5 irq cleared", irq, 0);
      if (more) wr(1'b0, nxt);
      run_byte(cur, more && idx[0], -1);
      if (more) check("R5 R6 irq on reload", irq, 1);
    end
    check("R7 underrun idle", dac_code, 4);
    check("R7 no irq", irq, 0);
    tick(1'b0); tick(1'b0);
    check("R7 stays idle", dac_code, 4);

    // Disable during a byte with a pending byte.
    ph = 0;
    wr(1'b0, 8'hC3);
    repeat (2) @(negedge clk);
    check("R3 restart code", dac_code, 3);
    clr_irq();
    wr(1'b0, 8'h3C);
    run_byte(8'hC3, 1'b0, 10);
    check("R8 off after finish", dac_code, 7);
    check("R8 no irq", irq, 0);
    tick(1'b0);
    check("R8 pending dropped", dac_code, 7);

    wr(1'b0, 8'h55);
    repeat (3) @(negedge clk);
    check("R9 write ignored dac", dac_code, 7);
    check("R9 write ignored irq", irq, 0);
    wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check("R9 nothing held", dac_code, 4);
    tick(1'b0);
    check("R9 still idle", dac_code, 4);
    check("R9 irq low", irq, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule